// File: doc/BRIEF.md
# Desaturation Blanking Timer and Per-Pulse Fault Latch

This block sits between a gate-drive command and an over-current (desaturation) comparator. At every turn-on of the gate command it opens a leading-edge blanking window. For that window it holds the sense node discharged and disregards the comparator. When the window closes it releases the discharge switch and enables the sense current source. The source then stays on for the rest of the on-time.

A comparator trip seen while sensing ends the current pulse at once. The trip raises the fault flag, which the surrounding drive logic uses to cut the gate. The flag stays high through the following off-time, so it can be read as a per-cycle fault indication. The next low-to-high edge of the command clears the flag and starts a fresh blanking window, so a trip never outlives the pulse it belongs to.

The comparator flag enters through a parameterised synchroniser. The blanking length is a parameter in clock cycles; for example, 50 cycles at a 100 MHz clock gives 500 ns. If the sense pin is tied to ground the comparator never asserts, and the protection never acts. All pins are plain level signals. No data moves through the block, so no valid/ready handshake is involved and no back-pressure rules apply.

Top module: `desat_guard`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, `sense_clamp` is 1, `src_en` is 0 and `fault` is 0. An asynchronous reset clears a latched fault.
- R2: When `gate_cmd` is sampled low at a clock edge, `sense_clamp` is 1 and `src_en` is 0 after that edge.
- R3: A rising edge of `gate_cmd` is a high sample that follows a low sample. The edge where it is sampled starts a blanking window. For exactly `BLANK_CYC` cycles after that edge, `sense_clamp` is 1 and `src_en` is 0. During the window `desat_hi` has no effect on any output.
- R4: At the end of the blanking window, if `gate_cmd` is still high, `sense_clamp` drops to 0 and `src_en` rises to 1. Both hold until `gate_cmd` falls or a trip occurs.
- R5: `desat_hi` passes through `SYNC_STAGES` registers. When its synchronised value is 1 at an edge during sensing, then after that edge `src_en` is 0, `sense_clamp` is 1 and `fault` is 1. Sensing does not resume within the same command pulse.
- R6: `fault` stays 1 through the rest of the pulse and the off-time. It clears at the edge that samples the next rising edge of `gate_cmd`, the same edge that starts a new blanking window.
- R7: If `gate_cmd` falls during blanking, the window is abandoned. The next rising edge restarts a full `BLANK_CYC` window.
- R8: With `desat_hi` held at 0, sensing lasts for the whole remaining on-time and `fault` never sets.
- R9: If `gate_cmd` is already high when reset is released, no blanking window or sensing takes place until `gate_cmd` has gone low and risen again.
- R10: If the synchronised comparator flag is already 1 when blanking ends, sensing lasts exactly one cycle before the trip of R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| gate_cmd | input | 1 | Gate-on command, 1 = transistor on |
| desat_hi | input | 1 | Comparator flag, 1 = sense voltage above threshold |
| sense_clamp | output | 1 | Enables the sense-node discharge switch |
| src_en | output | 1 | Enables the sense current source |
| fault | output | 1 | Trip flag for the present pulse, held until the next turn-on |

## Verification
If the blanking counter holds a wrong value, `src_en` rises too early or too late. This shows at the ports within one window of `BLANK_CYC + 1` cycles after a turn-on. If the phase is lost, `sense_clamp` and `src_en` disagree with the command one cycle after `gate_cmd` changes. If the fault latch is dropped or cleared early, `fault` goes low during the off-time on the very next cycle. A latch that fails to clear shows as `fault` still high one cycle after a turn-on. Trips that are missed, or trips accepted during blanking, appear `SYNC_STAGES + 1` cycles after the comparator moves.

// File: rtl/desat_pkg.sv
package desat_pkg;

  // Phase of the sense path within one gate pulse
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,  // gate off: node discharged, source off
    PH_BLANK = 2'd1,  // leading-edge window: node discharged, comparator ignored
    PH_SENSE = 2'd2,  // monitoring: source on, comparator armed
    PH_HALT  = 2'd3   // tripped: waiting for the command to fall
  } phase_t;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/desat_sync.sv
module desat_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flag_i,
  output logic flag_o
);

  generate
    if (STAGES == 0) begin : g_bypass
      assign flag_o = flag_i;
    end else begin : g_chain
      logic [STAGES-1:0] pipe_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else if (STAGES == 1) pipe_q <= flag_i;
        else pipe_q <= {pipe_q[STAGES-2:0], flag_i};
      end
      assign flag_o = pipe_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/desat_edge.sv
module desat_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic rise_o
);

  // Held high through reset so a command already on does not count as an edge
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= level_i;
  end

  assign rise_o = level_i & ~prev_q;

endmodule

// File: rtl/desat_blank_timer.sv
module desat_blank_timer #(
  parameter int unsigned BLANK_CYC = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  input  logic run_i,
  output logic expired_o
);

  localparam int unsigned CW   = desat_pkg::cnt_width(BLANK_CYC);
  localparam logic [CW-1:0] LAST = CW'(BLANK_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         cnt_q <= '0;
    else if (restart_i)                 cnt_q <= '0;
    else if (run_i && (cnt_q != LAST))  cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = run_i && (cnt_q == LAST);

endmodule

// File: rtl/desat_ctrl.sv
module desat_ctrl
  import desat_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic gate_i,
  input  logic rise_i,
  input  logic expired_i,
  input  logic trip_i,
  output logic restart_o,
  output logic blanking_o,
  output logic clamp_o,
  output logic src_o,
  output logic fault_o
);

  phase_t phase_q, phase_d;
  logic   fault_q, fault_d;
  logic   start;

  assign start = (phase_q == PH_IDLE) && rise_i;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:  if (start) phase_d = PH_BLANK;
      PH_BLANK: begin
        if (!gate_i)        phase_d = PH_IDLE;
        else if (expired_i) phase_d = PH_SENSE;
      end
      PH_SENSE: begin
        if (!gate_i)     phase_d = PH_IDLE;
        else if (trip_i) phase_d = PH_HALT;
      end
      PH_HALT:  if (!gate_i) phase_d = PH_IDLE;
      default:  phase_d = PH_IDLE;
    endcase
  end

  always_comb begin
    fault_d = fault_q;
    if (start)                                          fault_d = 1'b0;
    else if ((phase_q == PH_SENSE) && gate_i && trip_i) fault_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      fault_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      fault_q <= fault_d;
    end
  end

  assign restart_o  = start;
  assign blanking_o = (phase_q == PH_BLANK);
  assign src_o      = (phase_q == PH_SENSE);
  assign clamp_o    = (phase_q != PH_SENSE);
  assign fault_o    = fault_q;

endmodule

// File: rtl/desat_guard.sv
module desat_guard #(
  parameter int unsigned BLANK_CYC   = 50,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_cmd,
  input  logic desat_hi,
  output logic sense_clamp,
  output logic src_en,
  output logic fault
);

  logic trip_s;
  logic gate_rise;
  logic restart;
  logic blanking;
  logic expired;

  desat_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .flag_i (desat_hi),
    .flag_o (trip_s)
  );

  desat_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (gate_cmd),
    .rise_o  (gate_rise)
  );

  desat_blank_timer #(.BLANK_CYC(BLANK_CYC)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (restart),
    .run_i     (blanking),
    .expired_o (expired)
  );

  desat_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .gate_i     (gate_cmd),
    .rise_i     (gate_rise),
    .expired_i  (expired),
    .trip_i     (trip_s),
    .restart_o  (restart),
    .blanking_o (blanking),
    .clamp_o    (sense_clamp),
    .src_o      (src_en),
    .fault_o    (fault)
  );

endmodule

// File: rtl/desat_guard_chk.sv
module desat_guard_chk #(
  parameter int unsigned BLANK_CYC = 50
) (
  input logic clk,
  input logic rst_n,
  input logic gate_cmd,
  input logic desat_hi,
  input logic sense_clamp,
  input logic src_en,
  input logic fault
);

  localparam int unsigned RW = $clog2(BLANK_CYC + 1) + 1;

  // Length of the current stretch of "command high, not sensing", saturated
  logic [RW-1:0] run_cnt;
  logic          unused_in;

  assign unused_in = desat_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     run_cnt <= '0;
    else if (src_en || !gate_cmd)   run_cnt <= '0;
    else if (run_cnt < RW'(BLANK_CYC)) run_cnt <= run_cnt + 1'b1;
  end

  // R2: a low command sample leaves the node discharged and the source off
  a_r2_off_state: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(gate_cmd) |-> (sense_clamp && !src_en));

  // R3: sensing never starts before a full blanking window
  a_r3_full_window: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(src_en) |-> (run_cnt >= RW'(BLANK_CYC)));

  // R4: the source is only on while the command was on
  a_r4_src_needs_gate: assert property (@(posedge clk) disable iff (!rst_n)
    src_en |-> $past(gate_cmd));

  // R5: a new trip ends sensing in the same cycle
  a_r5_trip_stops_src: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> (!src_en && sense_clamp));

  // R6: the fault only clears on a fresh turn-on
  a_r6_fault_held: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !(gate_cmd && !$past(gate_cmd))) |=> fault);

endmodule

bind desat_guard desat_guard_chk #(.BLANK_CYC(BLANK_CYC)) u_desat_guard_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .gate_cmd    (gate_cmd),
  .desat_hi    (desat_hi),
  .sense_clamp (sense_clamp),
  .src_en      (src_en),
  .fault       (fault)
);

// File: tb/test_desat_guard.sv
module test_desat_guard;

  localparam int CLK_PERIOD = 10;
  localparam int BLANK      = 4;
  localparam int SYNC       = 1;
  localparam int NVEC       = 37;

  // {gate, cmp, exp_clamp, exp_src, exp_fault, req[3:0]}
  localparam logic [8:0] VEC [NVEC] = '{
    9'b0_0_100_0010, // 0  R2 idle
    9'b1_0_100_0011, // 1  R3 window opens
    9'b1_1_100_0011, // 2  R3 comparator ignored
    9'b1_1_100_0011, // 3  R3
    9'b1_0_100_0011, // 4  R3
    9'b1_0_010_0100, // 5  R4 sensing
    9'b1_0_010_0100, // 6  R4
    9'b1_1_010_0100, // 7  R4 comparator rises
    9'b1_0_101_0101, // 8  R5 trip
    9'b1_0_101_0101, // 9  R5 no re-arm
    9'b0_0_101_0110, // 10 R6 held in off-time
    9'b0_0_101_0110, // 11 R6
    9'b1_0_100_0110, // 12 R6 cleared at turn-on
    9'b1_0_100_0011, // 13 R3
    9'b1_0_100_0011, // 14 R3
    9'b1_0_100_0011, // 15 R3
    9'b1_0_010_0100, // 16 R4
    9'b0_0_100_0010, // 17 R2
    9'b1_1_100_0011, // 18 R3 comparator high all along
    9'b1_1_100_0011, // 19 R3
    9'b1_1_100_0011, // 20 R3
    9'b1_1_100_0011, // 21 R3
    9'b1_1_010_0100, // 22 R4 one sensing cycle
    9'b1_1_101_1010, // 23 R10 immediate trip
    9'b0_0_101_0110, // 24 R6
    9'b1_0_100_0110, // 25 R6 clear
    9'b0_0_100_0111, // 26 R7 abort during blanking
    9'b1_0_100_0111, // 27 R7 full restart
    9'b1_0_100_0111, // 28 R7
    9'b1_0_100_0111, // 29 R7
    9'b1_0_100_0111, // 30 R7
    9'b1_0_010_1000, // 31 R8 quiet comparator
    9'b1_0_010_1000, // 32 R8
    9'b1_0_010_1000, // 33 R8
    9'b1_0_010_1000, // 34 R8
    9'b1_0_010_1000, // 35 R8
    9'b0_0_100_0010  // 36 R2
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gate_cmd = 1'b0;
  logic desat_hi = 1'b0;
  logic sense_clamp, src_en, fault;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  desat_guard #(.BLANK_CYC(BLANK), .SYNC_STAGES(SYNC)) i_desat_guard (
    .clk         (clk),
    .rst_n       (rst_n),
    .gate_cmd    (gate_cmd),
    .desat_hi    (desat_hi),
    .sense_clamp (sense_clamp),
    .src_en      (src_en),
    .fault       (fault)
  );

  task automatic chk(input logic ec, input logic es, input logic ef, input int req);
    n_vec++;
    if ({sense_clamp, src_en, fault} !== {ec, es, ef}) begin
      n_bad++;
      $display("FAIL R%0d: clamp/src/fault = %b%b%b, expected %b%b%b",
               req, sense_clamp, src_en, fault, ec, es, ef);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_bad++;
      $display("FAIL R1: watchdog expired, actual hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state with the command held high
    gate_cmd = 1'b1;
    repeat (3) @(negedge clk);
    chk(1'b1, 1'b0, 1'b0, 1);
    rst_n = 1'b1;
    // R9: command high across reset release never opens a window
    for (int k = 0; k < BLANK + 3; k++) begin
      @(negedge clk);
      chk(1'b1, 1'b0, 1'b0, 9);
    end
    gate_cmd = 1'b0;
    @(negedge clk);
    chk(1'b1, 1'b0, 1'b0, 2);
    gate_cmd = 1'b1;
    for (int k = 0; k < BLANK; k++) begin
      @(negedge clk);
      chk(1'b1, 1'b0, 1'b0, 3);
    end
    @(negedge clk);
    chk(1'b0, 1'b1, 1'b0, 4);
    // R5: trip after synchroniser latency
    desat_hi = 1'b1;
    @(negedge clk);
    chk(1'b0, 1'b1, 1'b0, 5);
    @(negedge clk);
    chk(1'b1, 1'b0, 1'b1, 5);
    desat_hi = 1'b0;
    gate_cmd = 1'b0;
    @(negedge clk);
    chk(1'b1, 1'b0, 1'b1, 6);
    // R1: reset clears a latched fault
    rst_n = 1'b0;
    @(negedge clk);
    chk(1'b1, 1'b0, 1'b0, 1);
    rst_n = 1'b1;
    // Table walk
    for (int i = 0; i < NVEC; i++) begin
      gate_cmd = VEC[i][8];
      desat_hi = VEC[i][7];
      @(negedge clk);
      chk(VEC[i][6], VEC[i][5], VEC[i][4], int'(VEC[i][3:0]));
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule